// File: doc/BRIEF.md
# Clocked Serial I/O Port

This block moves one byte at a time over a three-wire synchronous serial link. Software writes a control byte, then writes the byte to send. Writing the send byte starts a transfer. Over eight serial clock periods the byte leaves on the data output, least significant bit first. At the same time, a byte is collected from the data input. When the eighth bit is in, a sticky interrupt flag is set and the received byte can be read back.

The serial clock has two possible sources. It can come from an internal divider of the system clock, with four selectable ratios. It can also come from an external pin, which is passed through a synchronizer before use. The block does not drive the shared device pins directly. Instead it presents enable and direction outputs so that the pad logic can hand the pins to the serial function. An optional ready output tells an external master that a byte is loaded and waiting for its clock.

Top module: `sio_port`

## Requirements
- R1: After reset the control register reads 0x00 (external clock, slowest-to-fastest code 00, pins released). The interrupt flag is 0, the clock output is 1, the clock drive enable is 0, all pin enables are 0, the data output is 1 and the ready output is 0.
- R2: A write with `bus_addr`=0 stores all 8 bits of the control register. A read with `bus_addr`=0 returns them unchanged.
- R3: When control bit 2 is 1 (internal clock), the serial clock is low for H and high for H system cycles. H is 4, 8, 16 or 256 for control bits [1:0] = 00, 01, 10, 11. The first falling edge comes H cycles after the send write. The interrupt flag rises 16·H cycles after the send write. Between transfers the clock rests high.
- R4: The data output changes only on a falling serial clock edge. It presents the send byte least significant bit first, so bit k is valid around the k-th rising edge.
- R5: The data input is sampled on each rising serial clock edge. The first bit sampled lands in bit 0. After the transfer, a read with `bus_addr`=1 returns the assembled byte.
- R6: After exactly eight rising edges the transfer stops and the interrupt flag is set. The flag stays set until the next write with `bus_addr`=1.
- R7: When control bit 2 is 0, the transfer is clocked by `sclk_in` after synchronization, and `sclk_oe` is 0.
- R8: `sclk_pin_en` and `sdata_pin_en` equal control bit 3. `sclk_oe` is bit 3 AND bit 2. `rdy_pin_en` is bit 3 AND bit 4.
- R9: When control bit 4 is 1, the ready output rises with an accepted send write and falls at the first falling serial clock edge.
- R10: A write with `bus_addr`=1 during a transfer is ignored. The received byte and the transfer length are unaffected.
- R11: Edges on `sclk_in` while no transfer is running shift nothing. The received byte, the data output and the interrupt flag keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 control, 1 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| sclk_in | input | 1 | External serial clock from the pad |
| sclk_out | output | 1 | Internally generated serial clock |
| sclk_oe | output | 1 | Clock pad drives `sclk_out` |
| sclk_pin_en | output | 1 | Clock pad assigned to the serial function |
| sin | input | 1 | Serial data input |
| sout | output | 1 | Serial data output |
| sdata_pin_en | output | 1 | Data pads assigned to the serial function |
| rdy_out | output | 1 | Byte loaded and waiting for the clock |
| rdy_pin_en | output | 1 | Ready pad assigned to the serial function |
| irq | output | 1 | Sticky transfer-complete flag |

## Verification
The hardest case to reach is a send write that arrives while a byte is already shifting. Only a mis-gated load reveals it, by restarting the bit count or overwriting the shift register. The stimulus reaches it by driving a data write in the middle of a transfer at the fastest divider setting. It then checks that the total length is still sixteen half periods and that the received byte matches the pattern. A second case that is hard to reach is external clock activity with no transfer running. The bench creates it by toggling `sclk_in` after a completed byte. It then confirms through the data register read and the flag that nothing moved.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int DATA_W = 8;
  localparam int CNT_W  = $clog2(DATA_W);

  typedef enum logic [1:0] {
    DIV_A = 2'b00,
    DIV_B = 2'b01,
    DIV_C = 2'b10,
    DIV_D = 2'b11
  } div_sel_e;

  typedef struct packed {
    logic [2:0] spare;
    logic       rdy_en;
    logic       pins_en;
    logic       int_clk;
    div_sel_e   div;
  } ctrl_t;
endpackage

// File: rtl/sio_rst_sync.sv
module sio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic s1_q;
  logic s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_s_n = s2_q;
endmodule

// File: rtl/sio_bitclk.sv
module sio_bitclk
  import sio_pkg::*;
#(
  parameter int HALF_A = 4,
  parameter int HALF_B = 8,
  parameter int HALF_C = 16,
  parameter int HALF_D = 256,
  parameter int HALF_W = $clog2(HALF_D + 1)
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  logic     int_sel,
  input  div_sel_e div,
  input  logic     ext_clk,
  output logic     sclk,
  output logic     fall_evt,
  output logic     rise_evt
);
  logic [HALF_W-1:0] half_sel;
  logic [HALF_W-1:0] tick_q, tick_n;
  logic              sclk_q, sclk_n;
  logic              ext_s1_q, ext_s2_q, ext_s3_q;
  logic              wrap;
  logic              ext_fall, ext_rise;

  always_comb begin
    unique case (div)
      DIV_A:   half_sel = HALF_W'(HALF_A);
      DIV_B:   half_sel = HALF_W'(HALF_B);
      DIV_C:   half_sel = HALF_W'(HALF_C);
      default: half_sel = HALF_W'(HALF_D);
    endcase
  end

  assign wrap     = (tick_q == half_sel - 1'b1);
  assign ext_fall = ext_s3_q & ~ext_s2_q;
  assign ext_rise = ~ext_s3_q & ext_s2_q;

  always_comb begin
    tick_n = tick_q;
    sclk_n = sclk_q;
    if (!run || !int_sel) begin
      tick_n = '0;
      sclk_n = 1'b1;
    end else if (wrap) begin
      tick_n = '0;
      sclk_n = ~sclk_q;
    end else begin
      tick_n = tick_q + 1'b1;
    end
  end

  always_comb begin
    if (int_sel) begin
      fall_evt = run & wrap & sclk_q;
      rise_evt = run & wrap & ~sclk_q;
    end else begin
      fall_evt = run & ext_fall;
      rise_evt = run & ext_rise;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q   <= '0;
      sclk_q   <= 1'b1;
      ext_s1_q <= 1'b1;
      ext_s2_q <= 1'b1;
      ext_s3_q <= 1'b1;
    end else begin
      tick_q   <= tick_n;
      sclk_q   <= sclk_n;
      ext_s1_q <= ext_clk;
      ext_s2_q <= ext_s1_q;
      ext_s3_q <= ext_s2_q;
    end
  end

  assign sclk = sclk_q;
endmodule

// File: rtl/sio_shift.sv
module sio_shift
  import sio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              fall_evt,
  input  logic              rise_evt,
  input  logic              sin,
  output logic [DATA_W-1:0] sreg,
  output logic              sout,
  output logic              busy,
  output logic              done
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sreg_q, sreg_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              busy_q, busy_n;
  logic              sout_q, sout_n;

  assign done = busy_q & rise_evt & (cnt_q == LAST);

  always_comb begin
    sreg_n = sreg_q;
    cnt_n  = cnt_q;
    busy_n = busy_q;
    sout_n = sout_q;
    if (load && !busy_q) begin
      sreg_n = load_data;
      cnt_n  = '0;
      busy_n = 1'b1;
    end else if (busy_q) begin
      if (fall_evt) begin
        sout_n = sreg_q[0];
      end
      if (rise_evt) begin
        sreg_n = {sin, sreg_q[DATA_W-1:1]};
        cnt_n  = cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          busy_n = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      sout_q <= 1'b1;
    end else begin
      sreg_q <= sreg_n;
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
      sout_q <= sout_n;
    end
  end

  assign sreg = sreg_q;
  assign sout = sout_q;
  assign busy = busy_q;
endmodule

// File: rtl/sio_port.sv
module sio_port
  import sio_pkg::*;
#(
  parameter int HALF_A = 4,
  parameter int HALF_B = 8,
  parameter int HALF_C = 16,
  parameter int HALF_D = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sclk_in,
  output logic              sclk_out,
  output logic              sclk_oe,
  output logic              sclk_pin_en,
  input  logic              sin,
  output logic              sout,
  output logic              sdata_pin_en,
  output logic              rdy_out,
  output logic              rdy_pin_en,
  output logic              irq
);
  localparam int HALF_W = $clog2(HALF_D + 1);

  logic              rst_s_n;
  ctrl_t             ctrl_q, ctrl_n;
  logic              irq_q, irq_n;
  logic              rdy_q, rdy_n;
  logic              ctrl_wr, data_wr, load;
  logic              busy, done, fall_evt, rise_evt;
  logic [DATA_W-1:0] sreg;

  sio_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  assign ctrl_wr = bus_we & ~bus_addr;
  assign data_wr = bus_we & bus_addr;
  assign load    = data_wr & ~busy;

  sio_bitclk #(
    .HALF_A (HALF_A),
    .HALF_B (HALF_B),
    .HALF_C (HALF_C),
    .HALF_D (HALF_D),
    .HALF_W (HALF_W)
  ) u_clk (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .run      (busy),
    .int_sel  (ctrl_q.int_clk),
    .div      (ctrl_q.div),
    .ext_clk  (sclk_in),
    .sclk     (sclk_out),
    .fall_evt (fall_evt),
    .rise_evt (rise_evt)
  );

  sio_shift u_shift (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .load      (load),
    .load_data (bus_wdata),
    .fall_evt  (fall_evt),
    .rise_evt  (rise_evt),
    .sin       (sin),
    .sreg      (sreg),
    .sout      (sout),
    .busy      (busy),
    .done      (done)
  );

  always_comb begin
    ctrl_n = ctrl_q;
    if (ctrl_wr) begin
      ctrl_n = ctrl_t'(bus_wdata);
    end
    irq_n = done | (irq_q & ~data_wr);
    rdy_n = rdy_q;
    if (load && ctrl_q.rdy_en) begin
      rdy_n = 1'b1;
    end else if (fall_evt) begin
      rdy_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ctrl_q <= '0;
      irq_q  <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      irq_q  <= irq_n;
      rdy_q  <= rdy_n;
    end
  end

  assign bus_rdata    = bus_addr ? sreg : DATA_W'(ctrl_q);
  assign sclk_pin_en  = ctrl_q.pins_en;
  assign sclk_oe      = ctrl_q.pins_en & ctrl_q.int_clk;
  assign sdata_pin_en = ctrl_q.pins_en;
  assign rdy_pin_en   = ctrl_q.pins_en & ctrl_q.rdy_en;
  assign rdy_out      = rdy_q;
  assign irq          = irq_q;
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_we,
  input logic bus_addr,
  input logic irq,
  input logic rdy_out,
  input logic sout,
  input logic sclk_out,
  input logic sclk_oe,
  input logic sclk_pin_en,
  input logic busy,
  input logic fall_evt,
  input logic done
);
  // R3: serial clock rests high whenever no transfer runs
  p_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk_out);

  // R4: data output moves only after a falling serial edge
  p_sout_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sout) |-> $past(fall_evt));

  // R6: flag is sticky until a data write
  p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(bus_we && bus_addr)) |=> irq);

  // R6: flag rises only at the end of a byte
  p_irq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(done));

  // R8: clock drive only on an assigned pin
  p_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_oe |-> sclk_pin_en);

  // R9: ready drops at the first falling edge
  p_rdy_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_out && fall_evt) |=> !rdy_out);
endmodule

bind sio_port sio_port_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_s_n),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .irq         (irq),
  .rdy_out     (rdy_out),
  .sout        (sout),
  .sclk_out    (sclk_out),
  .sclk_oe     (sclk_oe),
  .sclk_pin_en (sclk_pin_en),
  .busy        (busy),
  .fall_evt    (fall_evt),
  .done        (done)
);

// File: tb/tb_sio_port.sv
`timescale 1ns/1ps
module tb_sio_port;
  logic       clk;
  logic       rst_n;
  logic       bus_we;
  logic       bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       sclk_in;
  logic       sclk_out, sclk_oe, sclk_pin_en;
  logic       sin, sout, sdata_pin_en;
  logic       rdy_out, rdy_pin_en, irq;

  int n_checks = 0;
  int n_fail   = 0;

  sio_port dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .sclk_in      (sclk_in),
    .sclk_out     (sclk_out),
    .sclk_oe      (sclk_oe),
    .sclk_pin_en  (sclk_pin_en),
    .sin          (sin),
    .sout         (sout),
    .sdata_pin_en (sdata_pin_en),
    .rdy_out      (rdy_out),
    .rdy_pin_en   (rdy_pin_en),
    .irq          (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input bit a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input bit a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] r;
    bus_read(1'b0, r);
    check(r == 8'h00, "R1 ctrl", r, 0);
    check(irq == 0 && sclk_out == 1 && sout == 1 && rdy_out == 0, "R1 outputs",
          {irq, sclk_out, sout, rdy_out}, 4'b0110);
    check(sclk_oe == 0 && sclk_pin_en == 0 && sdata_pin_en == 0 && rdy_pin_en == 0,
          "R1 pins", {sclk_oe, sclk_pin_en, sdata_pin_en, rdy_pin_en}, 0);
  endtask

  task automatic t_ctrl_rw();
    logic [7:0] r;
    bus_write(1'b0, 8'hA7);
    bus_read(1'b0, r);
    check(r == 8'hA7, "R2 readback", r, 8'hA7);
    bus_write(1'b0, 8'h58);
    bus_read(1'b0, r);
    check(r == 8'h58, "R2 readback", r, 8'h58);
  endtask

  task automatic t_pins();
    bus_write(1'b0, 8'h08);
    check({sclk_pin_en, sclk_oe, sdata_pin_en, rdy_pin_en} == 4'b1010, "R8 ext clk",
          {sclk_pin_en, sclk_oe, sdata_pin_en, rdy_pin_en}, 4'b1010);
    bus_write(1'b0, 8'h1C);
    check({sclk_pin_en, sclk_oe, sdata_pin_en, rdy_pin_en} == 4'b1111, "R8 int clk rdy",
          {sclk_pin_en, sclk_oe, sdata_pin_en, rdy_pin_en}, 4'b1111);
    bus_write(1'b0, 8'h14);
    check({sclk_pin_en, sclk_oe, sdata_pin_en, rdy_pin_en} == 4'b0000, "R8 released",
          {sclk_pin_en, sclk_oe, sdata_pin_en, rdy_pin_en}, 0);
  endtask

  // Internal-clock transfer; optional mid-transfer data write (R10)
  task automatic t_int(input logic [1:0] code, input int half, input logic [7:0] tx,
                       input logic [7:0] rxpat, input bit use_rdy, input bit poke);
    logic [7:0] sent;
    logic [7:0] r;
    int  n = 0;
    int  ri = 0;
    int  fi = 0;
    int  first_fall = -1;
    bit  prev;
    sent = '0;
    bus_write(1'b0, {3'b000, use_rdy, 1'b1, 1'b1, code});
    bus_write(1'b1, tx);
    check(irq == 0, "R6 clear on write", irq, 0);
    if (use_rdy) check(rdy_out == 1, "R9 ready set", rdy_out, 1);
    prev = sclk_out;
    while (irq == 0 && n < 20000) begin
      @(negedge clk);
      n++;
      if (poke && n == 3) begin
        bus_we = 1'b1; bus_addr = 1'b1; bus_wdata = ~tx;
      end else begin
        bus_we = 1'b0;
      end
      if (use_rdy && n == half - 1) check(rdy_out == 1, "R9 ready held", rdy_out, 1);
      if (use_rdy && n == half) check(rdy_out == 0, "R9 ready drop", rdy_out, 0);
      if (prev && !sclk_out) begin
        if (first_fall < 0) first_fall = n;
        if (fi < 8) sin = rxpat[fi];
        fi++;
      end
      if (!prev && sclk_out) begin
        if (ri < 8) sent[ri] = sout;
        ri++;
      end
      prev = sclk_out;
    end
    bus_we = 1'b0;
    check(first_fall == half, "R3 first fall", first_fall, half);
    check(n == 16 * half, poke ? "R10 length" : "R3 length", n, 16 * half);
    check(ri == 8, "R6 eight edges", ri, 8);
    check(sent == tx, "R4 lsb first", sent, tx);
    bus_read(1'b1, r);
    check(r == rxpat, poke ? "R10 rx intact" : "R5 rx byte", r, rxpat);
    repeat (5) @(negedge clk);
    check(irq == 1 && sclk_out == 1, "R6 sticky, R3 idle high", {irq, sclk_out}, 2'b11);
  endtask

  task automatic t_ext(input logic [7:0] tx, input logic [7:0] rxpat);
    logic [7:0] sent;
    logic [7:0] r;
    logic       s_hold;
    sent = '0;
    bus_write(1'b0, 8'h18);
    check(sclk_oe == 0, "R7 no drive", sclk_oe, 0);
    bus_write(1'b1, tx);
    check(rdy_out == 1, "R9 ready ext", rdy_out, 1);
    for (int i = 0; i < 8; i++) begin
      sclk_in = 1'b0;
      sin = rxpat[i];
      repeat (6) @(negedge clk);
      sent[i] = sout;
      if (i == 0) check(rdy_out == 0, "R9 ready drop ext", rdy_out, 0);
      sclk_in = 1'b1;
      repeat (6) @(negedge clk);
    end
    check(irq == 1, "R7 irq", irq, 1);
    check(sent == tx, "R7 tx bits", sent, tx);
    bus_read(1'b1, r);
    check(r == rxpat, "R7 rx byte", r, rxpat);
    // idle edges must not shift (R11)
    s_hold = sout;
    for (int i = 0; i < 8; i++) begin
      sclk_in = 1'b0; sin = ~sin;
      repeat (6) @(negedge clk);
      sclk_in = 1'b1;
      repeat (6) @(negedge clk);
    end
    bus_read(1'b1, r);
    check(r == rxpat, "R11 rx unchanged", r, rxpat);
    check(sout == s_hold && irq == 1, "R11 sout irq", {sout, irq}, {s_hold, 1'b1});
  endtask

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = 1'b0; bus_wdata = '0;
    sclk_in = 1'b1; sin = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_ctrl_rw();
    t_pins();
    t_int(2'b00, 4,   8'hA5, 8'h3C, 1'b1, 1'b0);
    t_int(2'b01, 8,   8'h81, 8'hE7, 1'b0, 1'b0);
    t_int(2'b10, 16,  8'h6D, 8'h12, 1'b1, 1'b0);
    t_int(2'b11, 256, 8'hC3, 8'h5A, 1'b0, 1'b0);
    t_int(2'b00, 4,   8'h0F, 8'hB4, 1'b0, 1'b1);
    t_ext(8'h96, 8'h71);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule